// File: doc/BRIEF.md
# Per-Locality Interrupt Enable and Status

This block holds one interrupt-enable register and one interrupt-status register for each locality of a multi-locality register interface. Interrupt sources arrive as single-cycle pulses. Each pulse carries a locality number and a four-bit source vector. A source bit is latched into the status register of that locality only when the enable register of that locality has both its global enable bit and the matching source bit set.

A single shared interrupt line is driven active-low. It is low while any status bit of any locality is set. Software clears status bits by writing ones to them. Software may write the enable and status registers only from the currently active locality, and the block ignores writes from any other locality.

The enable register has a two-bit polarity field that software can store. The line itself always behaves as level-low. Software reads back both registers of a selected locality through a combinational read port.

Top module: `loc_irq_ctrl`

## Requirements
- R1: After reset every enable register reads 0x00000008 (level-low polarity, bit 3 set), every status register reads 0, and irq_n is high.
- R2: An event pulse sets a status bit only when the enable register of the tagged locality has bit 31 set and the matching source bit set. Source vector index 0 maps to bit 0 (data available), index 1 to bit 1 (status valid), index 2 to bit 2 (locality changed) and index 3 to bit 7 (command ready). The bit is visible on the read port in the cycle after the pulse.
- R3: When one pulse carries several source bits, each enabled bit is latched independently and the disabled ones are not.
- R4: Writes to either register take effect only when act_valid is high and wr_loc equals act_loc. Any other write leaves both registers of every locality unchanged.
- R5: In the enable register only bits 31, 7, 4, 3, 2, 1 and 0 are writable (mask 0x8000009F), and the other bits always read 0. Only the bytes whose wr_be bit is set are updated, and unaddressed bytes keep their value.
- R6: Writing to the status register (wr_sel=1) clears each bit that is written as 1 in an addressed byte. Only bits 0, 1, 2 and 7 can be cleared.
- R7: irq_n is low in every cycle in which any status bit of any locality is set, and high once all status registers are zero.
- R8: Event pulses tagged with a locality value of NUM_LOC or more are ignored.
- R9: If an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | A locality is currently active |
| act_loc | input | 3 | Number of the active locality |
| wr_en | input | 1 | Register write strobe |
| wr_loc | input | 3 | Locality that issues the write |
| wr_sel | input | 1 | 0 selects the enable register, 1 selects the status register |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| evt_valid | input | 1 | Event pulse |
| evt_loc | input | 3 | Locality tag of the event |
| evt_src | input | 4 | Source vector of the event |
| rd_loc | input | 3 | Locality selected for readback |
| rd_inte | output | 32 | Enable register of rd_loc (0 if rd_loc is invalid) |
| rd_ints | output | 32 | Status register of rd_loc (0 if rd_loc is invalid) |
| irq_n | output | 1 | Shared active-low interrupt line |

## Verification
A corrupted status bit shows up on irq_n in the cycle after the edge that corrupted it. When other localities are quiet, the same bit also shows on rd_ints of its locality in that cycle. A corrupted enable bit stays hidden until the next event for that locality. At that point it latches a bit it should not latch, or drops one it should latch, one cycle after the pulse. For this reason the reference comparison reads all localities in every cycle, so that a wrong enable value is caught right away rather than at the next event.

// File: rtl/loc_irq_ctrl.sv
module loc_irq_ctrl #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3,
  parameter int DW      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_valid,
  input  logic [LOC_W-1:0] act_loc,
  input  logic             wr_en,
  input  logic [LOC_W-1:0] wr_loc,
  input  logic             wr_sel,
  input  logic [DW/8-1:0]  wr_be,
  input  logic [DW-1:0]    wr_data,
  input  logic             evt_valid,
  input  logic [LOC_W-1:0] evt_loc,
  input  logic [3:0]       evt_src,
  input  logic [LOC_W-1:0] rd_loc,
  output logic [DW-1:0]    rd_inte,
  output logic [DW-1:0]    rd_ints,
  output logic             irq_n
);
  localparam logic [DW-1:0] SRC_MASK = DW'(32'h0000_0087);
  localparam logic [DW-1:0] EN_WMASK = DW'(32'h8000_009F);
  localparam logic [DW-1:0] EN_RST   = DW'(32'h0000_0008);
  localparam int            GEN_BIT  = 31;

  logic [DW-1:0] inte_q [NUM_LOC];
  logic [DW-1:0] ints_q [NUM_LOC];
  logic [NUM_LOC-1:0] pend;
  logic [DW-1:0] bmask;
  logic [DW-1:0] evt_mask;
  logic wr_ok;

  assign wr_ok    = wr_en && act_valid && (wr_loc == act_loc) && (32'(wr_loc) < NUM_LOC);
  assign evt_mask = DW'({evt_src[3], 4'b0000, evt_src[2:0]});

  always_comb begin
    for (int b = 0; b < DW/8; b++) bmask[b*8 +: 8] = {8{wr_be[b]}};
  end

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
    logic wr_here, evt_here;
    logic [DW-1:0] clr, set;
    assign wr_here  = wr_ok && (wr_loc == LOC_W'(g));
    assign evt_here = evt_valid && (evt_loc == LOC_W'(g)) && inte_q[g][GEN_BIT];
    assign clr = (wr_here && wr_sel) ? (wr_data & bmask & SRC_MASK) : '0;
    assign set = evt_here ? (evt_mask & inte_q[g]) : '0;
    assign pend[g] = |ints_q[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        inte_q[g] <= EN_RST;
        ints_q[g] <= '0;
      end else begin
        if (wr_here && !wr_sel)
          inte_q[g] <= (inte_q[g] & ~bmask) | (wr_data & bmask & EN_WMASK);
        ints_q[g] <= (ints_q[g] & ~clr) | set;
      end
    end

    // R2
    evt_only_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(ints_q[g] & ~$past(ints_q[g]))) |->
        $past(evt_valid && evt_loc == LOC_W'(g) && inte_q[g][GEN_BIT]));
    // R4
    inte_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(inte_q[g]) |->
        $past(wr_en && !wr_sel && act_valid && act_loc == LOC_W'(g) && wr_loc == LOC_W'(g)));
  end

  assign irq_n   = ~|pend;
  assign rd_inte = (32'(rd_loc) < NUM_LOC) ? inte_q[rd_loc] : '0;
  assign rd_ints = (32'(rd_loc) < NUM_LOC) ? ints_q[rd_loc] : '0;

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> $past(wr_en && wr_sel && act_valid && wr_loc == act_loc));
  // R8
  bad_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && 32'(evt_loc) >= NUM_LOC && !wr_en) |=> $stable(irq_n));
endmodule

// File: tb/loc_irq_ctrl_bench.sv
`timescale 1ns/100ps
module loc_irq_ctrl_bench;
  localparam int N = 5;
  logic clk = 0, rst_n = 0;
  logic act_valid = 0, wr_en = 0, wr_sel = 0, evt_valid = 0;
  logic [2:0] act_loc = 0, wr_loc = 0, evt_loc = 0, rd_loc = 0;
  logic [3:0] wr_be = 0, evt_src = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_inte, rd_ints;
  logic irq_n;
  int errors = 0, checks = 0;
  logic [31:0] m_inte [N];
  logic [31:0] m_ints [N];
  logic [31:0] g_inte [N];
  logic [31:0] g_ints [N];
  logic g_irq;

  loc_irq_ctrl u_loc_irq_ctrl (.clk, .rst_n, .act_valid, .act_loc, .wr_en, .wr_loc,
    .wr_sel, .wr_be, .wr_data, .evt_valid, .evt_loc, .evt_src, .rd_loc,
    .rd_inte, .rd_ints, .irq_n);

  always #2 clk = ~clk;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%08h exp=%08h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < N; l++) begin m_inte[l] = 32'h8; m_ints[l] = 0; end
    end else begin
      logic [31:0] bm, em, clr, st;
      bm = 0;
      for (int b = 0; b < 4; b++) if (wr_be[b]) bm = bm | (32'hFF << (8*b));
      em = 0;
      if (evt_src[0]) em = em | 32'h1;
      if (evt_src[1]) em = em | 32'h2;
      if (evt_src[2]) em = em | 32'h4;
      if (evt_src[3]) em = em | 32'h80;
      for (int l = 0; l < N; l++) begin
        bit ok;
        ok = wr_en && act_valid && act_loc == wr_loc && int'(wr_loc) == l;
        clr = (ok && wr_sel) ? (wr_data & bm & 32'h87) : 0;
        st  = (evt_valid && int'(evt_loc) == l && m_inte[l][31]) ? (em & m_inte[l]) : 0;
        if (ok && !wr_sel) m_inte[l] = (m_inte[l] & ~bm) | (wr_data & bm & 32'h8000009F);
        m_ints[l] = (m_ints[l] & ~clr) | st;
      end
    end
  end

  always @(negedge clk) begin
    logic any;
    any = 0;
    for (int l = 0; l < N; l++) begin
      rd_loc = 3'(l);
      #0.2;
      g_inte[l] = rd_inte; g_ints[l] = rd_ints;
      if (rst_n) begin
        chk("R5 enable compare", rd_inte, m_inte[l]);
        chk("R2 status compare", rd_ints, m_ints[l]);
      end
      any = any | (m_ints[l] != 0);
    end
    g_irq = irq_n;
    if (rst_n) chk("R7 irq compare", {31'b0, irq_n}, {31'b0, ~any});
  end

  task automatic cyc(input bit we, input bit sel, input [2:0] wl, input [3:0] be,
                     input [31:0] d, input bit ev, input [2:0] el, input [3:0] es);
    @(posedge clk); #1;
    wr_en = we; wr_sel = sel; wr_loc = wl; wr_be = be; wr_data = d;
    evt_valid = ev; evt_loc = el; evt_src = es;
    @(posedge clk); #1;
    wr_en = 0; evt_valid = 0;
    @(negedge clk); #1.5;
  endtask

  initial begin
    #(200000*4);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1.5;
    chk("R1 inte loc0", g_inte[0], 32'h8);
    chk("R1 inte loc4", g_inte[4], 32'h8);
    chk("R1 ints loc0", g_ints[0], 0);
    chk("R1 irq_n", {31'b0, g_irq}, 1);
    cyc(1, 0, 0, 4'hF, 32'hFFFF_FFFF, 0, 0, 0);
    chk("R4 no active locality", g_inte[0], 32'h8);
    act_valid = 1; act_loc = 0;
    cyc(1, 0, 0, 4'hF, 32'hFFFF_FFFF, 0, 0, 0);
    chk("R5 writable mask", g_inte[0], 32'h8000_009F);
    cyc(0, 0, 0, 0, 0, 1, 0, 4'b0001);
    chk("R2 data-available latched", g_ints[0], 32'h1);
    chk("R7 irq low", {31'b0, g_irq}, 0);
    cyc(0, 0, 0, 0, 0, 1, 1, 4'b1111);
    chk("R2 disabled locality", g_ints[1], 0);
    cyc(1, 1, 1, 4'hF, 32'hFF, 0, 0, 0);
    chk("R6 clear from inactive ignored", g_ints[0], 32'h1);
    cyc(1, 1, 0, 4'hF, 32'h1, 0, 0, 0);
    chk("R6 clear", g_ints[0], 0);
    chk("R7 irq high", {31'b0, g_irq}, 1);
    cyc(0, 0, 0, 0, 0, 1, 0, 4'b1010);
    chk("R3 two sources", g_ints[0], 32'h82);
    cyc(1, 0, 0, 4'b0001, 32'h0000_0001, 0, 0, 0);
    chk("R5 byte write", g_inte[0], 32'h8000_0001);
    cyc(0, 0, 0, 0, 0, 1, 0, 4'b1111);
    chk("R3 only enabled source", g_ints[0], 32'h83);
    cyc(0, 0, 0, 0, 0, 1, 5, 4'b1111);
    cyc(0, 0, 0, 0, 0, 1, 7, 4'b1111);
    chk("R8 invalid locality", g_ints[0], 32'h83);
    cyc(1, 1, 0, 4'hF, 32'hFFFF_FFFF, 1, 0, 4'b0001);
    chk("R9 set wins", g_ints[0], 32'h1);
    cyc(1, 1, 0, 4'b0010, 32'hFFFF_FFFF, 0, 0, 0);
    chk("R6 unaddressed byte kept", g_ints[0], 32'h1);
    act_loc = 2;
    cyc(1, 0, 0, 4'hF, 32'h0, 0, 0, 0);
    chk("R4 other active", g_inte[0], 32'h8000_0001);
    cyc(1, 1, 0, 4'hF, 32'hFF, 0, 0, 0);
    chk("R6 status gated", g_ints[0], 32'h1);
    cyc(1, 0, 2, 4'b1001, 32'h8000_00FF, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 2, 4'b0100);
    chk("R2 locality-changed bit2", g_ints[2], 32'h4);
    act_loc = 0;
    cyc(1, 1, 0, 4'hF, 32'h1, 0, 0, 0);
    chk("R7 irq held by other locality", {31'b0, g_irq}, 0);
    act_loc = 2;
    cyc(1, 1, 2, 4'hF, 32'h4, 0, 0, 0);
    chk("R7 irq released", {31'b0, g_irq}, 1);
    repeat (4) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule